// File: doc/BRIEF.md
# USB Full-Speed Line Transmitter

This block turns a stream of bytes into full-speed USB signalling on a pair of general-purpose pins. No external transceiver chip is involved. A sender presents bytes with a valid/ready handshake in the 12 MHz byte clock domain. The block takes each byte into a one-entry holding register. A line-side engine runs on a phase-related clock at four times that rate. It opens every packet with a synchronisation byte and then shifts the data out least significant bit first. A zero bit is inserted after every run of six ones, and the result is NRZI-coded onto the pin pair. The packet closes with an end-of-packet pattern, and the block then releases the pins.

The two clocks share edges: every byte-clock rising edge is also a line-clock rising edge. Because of this, signals pass between the domains without synchronisers. The holding register and a pair of toggle flags form the handshake between the domains.

A mode input and a speed-select input decide whether the pins are driven at all. One mode code releases the lines. A second mode code sends the bits without stuffing. A speed-select code of zero stops all driving, so that a high-speed detection sequence elsewhere is not disturbed. In both cases where driving is off, the packet is still serialised and consumed.

The engine is a state machine with six states:
- `ST_IDLE`: the line rests at J. It leaves for `ST_SYNC` when a fresh byte is held.
- `ST_SYNC`: sends the synchronisation pattern.
- `ST_DATA`: sends payload bits.
- `ST_STUFF`: sends an inserted zero. It is entered from `ST_SYNC`, `ST_DATA` or `ST_STUFF`'s successors whenever the run of ones reaches six and stuffing is enabled. It returns to `ST_SYNC` or `ST_DATA`.
- `ST_SE0`: reached from `ST_SYNC`, `ST_DATA` or `ST_STUFF` when a byte is exhausted and no fresh byte is held. It drives both lines low.
- `ST_EOPJ`: follows the last SE0 bit, drives one J bit, and returns to `ST_IDLE`.

Top module: `usbfs_tx`

## Requirements
- R1: Out of reset and whenever no packet is in flight, line_p is 1, line_n is 0 (the J state), line_drive is 0, and byte_ready is 0 while byte_valid is 0.
- R2: byte_ready is high only while byte_valid is high, and it is high for exactly one byte-clock cycle for each byte the block takes. Bytes go onto the wire in the order they were accepted.
- R3: Each packet begins, one line-clock cycle after its first byte is accepted, with the pattern 8'h80 sent least significant bit first. On the pins this reads K J K J K J K K, where J is {line_p,line_n}=2'b10 and K is 2'b01.
- R4: Payload bits follow the sync pattern least significant bit first. The pin state is unchanged for a 1 and swaps between J and K for a 0.
- R5: With stuffing enabled, a 0 is inserted after six consecutive 1 bits. The run counts the final 1 of the sync pattern, and a run completed by the last payload bit still gets its 0 before the end of packet.
- R6: After the last bit the pins carry two bit times of SE0 ({line_p,line_n}=2'b00), then one bit time of J. line_drive then falls.
- R7: Every bit, stuffed bit and end-of-packet symbol lasts exactly CYC_PER_BIT (default 4) line-clock cycles.
- R8: With mode_sel = 2'b01, line_drive stays 0 for the whole packet. The bytes are still consumed.
- R9: With mode_sel = 2'b10, no stuffed bits are inserted, however long a run of ones is.
- R10: With speed_sel = 2'b00, line_drive stays 0 for the whole packet, whatever mode_sel is.
- R11: mode_sel = 2'b11 behaves exactly like mode_sel = 2'b00, with stuffing and driving both on. line_drive is high from the first sync symbol through the final J.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| byte_clk | input | 1 | Byte-side clock, one quarter of line_clk, edges aligned |
| line_clk | input | 1 | Bit-timing clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| byte_in | input | 8 | Byte to send, valid while byte_valid is high |
| byte_valid | input | 1 | Sender has a byte; dropping it ends the packet |
| byte_ready | output | 1 | Byte on byte_in is taken at this byte_clk edge |
| mode_sel | input | 2 | 0/3 normal, 1 lines released, 2 stuffing off |
| speed_sel | input | 2 | 2'b00 stops all driving; other codes full speed |
| line_p | output | 1 | Positive data line level |
| line_n | output | 1 | Negative data line level |
| line_drive | output | 1 | Output enable for both data lines |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, four line cycles per bit, a stuffing run of six and two SE0 bits. With a sync byte that ends in a 1, an all-ones first payload byte reaches the stuffing threshold after only five of its bits. A byte whose top six bits are ones forces a stuffed bit right before SE0. Four cycles per bit keep each packet short enough that every mode and speed code gets a packet of its own, and the reference model is compared against every line-clock cycle.

// File: rtl/usbfs_tx_pkg.sv
package usbfs_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_STUFF,
        ST_SE0,
        ST_EOPJ
    } tx_state_e;

    // Pin pair coding as {positive, negative}
    localparam logic [1:0] SYM_J   = 2'b10;
    localparam logic [1:0] SYM_K   = 2'b01;
    localparam logic [1:0] SYM_SE0 = 2'b00;

    localparam logic [1:0] MODE_RELEASE = 2'b01;
    localparam logic [1:0] MODE_RAW     = 2'b10;
    localparam logic [1:0] SPEED_HS     = 2'b00;

endpackage

// File: rtl/usbfs_tx_hold.sv
module usbfs_tx_hold #(
    parameter int BYTE_W = 8
) (
    input  logic              byte_clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic              take_flag,
    output logic              held_fresh,
    output logic [BYTE_W-1:0] held_byte
);

    logic              full_q;
    logic              ack_q;
    logic [BYTE_W-1:0] data_q;

    assign byte_ready = byte_valid & ~full_q;
    assign held_byte  = data_q;
    // A byte is fresh until the line side has toggled take_flag for it
    assign held_fresh = full_q & (take_flag == ack_q);

    always_ff @(posedge byte_clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            ack_q  <= 1'b0;
            data_q <= '0;
        end else if (byte_ready) begin
            data_q <= byte_in;
            full_q <= 1'b1;
        end else if (full_q && (take_flag != ack_q)) begin
            full_q <= 1'b0;
            ack_q  <= take_flag;
        end
    end

    // R2
    single_accept_chk: assert property (@(posedge byte_clk) disable iff (!rst_n)
        (byte_valid && byte_ready) |=> !byte_ready);

    // R2
    held_until_taken_chk: assert property (@(posedge byte_clk) disable iff (!rst_n)
        (full_q && (take_flag == ack_q)) |=> full_q);

endmodule

// File: rtl/usbfs_tx_bittimer.sv
module usbfs_tx_bittimer #(
    parameter int CYC_PER_BIT = 4
) (
    input  logic line_clk,
    input  logic rst_n,
    input  logic active,
    output logic bit_end
);

    localparam int TMR_W = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(CYC_PER_BIT - 1);

    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge line_clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (!active || (tmr_q == TMR_LAST)) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + TMR_W'(1);
        end
    end

    assign bit_end = active && (tmr_q == TMR_LAST);

    // R7
    first_cycle_chk: assert property (@(posedge line_clk) disable iff (!rst_n)
        (!active) |=> (tmr_q == '0));

endmodule

// File: rtl/usbfs_tx_engine.sv
module usbfs_tx_engine
    import usbfs_tx_pkg::*;
#(
    parameter int                BYTE_W       = 8,
    parameter int                STUFF_RUN    = 6,
    parameter int                SE0_BITS     = 2,
    parameter logic [BYTE_W-1:0] SYNC_PATTERN = BYTE_W'(8'h80)
) (
    input  logic              line_clk,
    input  logic              rst_n,
    input  logic              bit_end,
    input  logic              stuff_on,
    input  logic              held_fresh,
    input  logic [BYTE_W-1:0] held_byte,
    output logic              take_flag,
    output logic              busy,
    output logic [1:0]        sym
);

    localparam int IDX_W = $clog2(BYTE_W + 1);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);
    localparam int SE0_W = (SE0_BITS > 1) ? $clog2(SE0_BITS) : 1;
    localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(BYTE_W);
    localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(STUFF_RUN);
    localparam logic [SE0_W-1:0] SE0_LAST = SE0_W'(SE0_BITS - 1);

    tx_state_e         state_q, state_n;
    logic [BYTE_W-1:0] shreg_q, shreg_n;
    logic [IDX_W-1:0]  idx_q,   idx_n;
    logic [RUN_W-1:0]  ones_q,  ones_n;
    logic [SE0_W-1:0]  se0_q,   se0_n;
    logic              lvl_q,   lvl_n;
    logic              take_q,  take_n;
    logic              insync_q, insync_n;

    logic              step;
    logic              emit;
    logic              src_bit;
    logic [RUN_W-1:0]  base_ones;

    // Idle waits for a held byte; every other state advances once per bit time
    assign step = (state_q == ST_IDLE) ? held_fresh : bit_end;

    // Next-state process
    always_comb begin
        state_n   = state_q;
        shreg_n   = shreg_q;
        idx_n     = idx_q;
        ones_n    = ones_q;
        se0_n     = se0_q;
        lvl_n     = lvl_q;
        take_n    = take_q;
        insync_n  = insync_q;
        emit      = 1'b0;
        src_bit   = 1'b0;
        base_ones = (state_q == ST_IDLE) ? '0 : ones_q;

        if (step) begin
            unique case (state_q)
                ST_EOPJ: begin
                    state_n = ST_IDLE;
                    lvl_n   = 1'b1;
                end
                ST_SE0: begin
                    if (se0_q == SE0_LAST) begin
                        state_n = ST_EOPJ;
                        lvl_n   = 1'b1;
                    end else begin
                        se0_n = se0_q + SE0_W'(1);
                    end
                end
                default: begin
                    if ((state_q != ST_IDLE) && stuff_on && (ones_q == RUN_MAX)) begin
                        state_n = ST_STUFF;
                        lvl_n   = ~lvl_q;
                        ones_n  = '0;
                    end else if (state_q == ST_IDLE) begin
                        src_bit  = SYNC_PATTERN[0];
                        shreg_n  = SYNC_PATTERN >> 1;
                        idx_n    = IDX_W'(1);
                        insync_n = 1'b1;
                        state_n  = ST_SYNC;
                        emit     = 1'b1;
                    end else if (idx_q != IDX_FULL) begin
                        src_bit = shreg_q[0];
                        shreg_n = shreg_q >> 1;
                        idx_n   = idx_q + IDX_W'(1);
                        state_n = insync_q ? ST_SYNC : ST_DATA;
                        emit    = 1'b1;
                    end else if (held_fresh) begin
                        src_bit  = held_byte[0];
                        shreg_n  = held_byte >> 1;
                        idx_n    = IDX_W'(1);
                        take_n   = ~take_q;
                        insync_n = 1'b0;
                        state_n  = ST_DATA;
                        emit     = 1'b1;
                    end else begin
                        se0_n   = '0;
                        state_n = ST_SE0;
                    end
                    if (emit) begin
                        if (src_bit) begin
                            ones_n = (base_ones == RUN_MAX) ? base_ones
                                                            : base_ones + RUN_W'(1);
                        end else begin
                            lvl_n  = ~lvl_q;
                            ones_n = '0;
                        end
                    end
                end
            endcase
        end
    end

    // State register process
    always_ff @(posedge line_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            shreg_q  <= '0;
            idx_q    <= '0;
            ones_q   <= '0;
            se0_q    <= '0;
            lvl_q    <= 1'b1;
            take_q   <= 1'b0;
            insync_q <= 1'b0;
        end else begin
            state_q  <= state_n;
            shreg_q  <= shreg_n;
            idx_q    <= idx_n;
            ones_q   <= ones_n;
            se0_q    <= se0_n;
            lvl_q    <= lvl_n;
            take_q   <= take_n;
            insync_q <= insync_n;
        end
    end

    // Output process
    always_comb begin
        busy      = (state_q != ST_IDLE);
        take_flag = take_q;
        if (state_q == ST_SE0) begin
            sym = SYM_SE0;
        end else begin
            sym = lvl_q ? SYM_J : SYM_K;
        end
    end

    // R7
    symbol_hold_chk: assert property (@(posedge line_clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && !bit_end) |=> $stable(sym));

    // R6
    se0_then_j_chk: assert property (@(posedge line_clk) disable iff (!rst_n)
        (state_q == ST_SE0) |=> ((state_q == ST_SE0) || (state_q == ST_EOPJ)));

    // R5
    stuff_after_run_chk: assert property (@(posedge line_clk) disable iff (!rst_n)
        ((state_q == ST_STUFF) && !$stable(state_q)) |-> ($past(ones_q) == RUN_MAX));

    // R9
    raw_no_stuff_chk: assert property (@(posedge line_clk) disable iff (!rst_n)
        (!stuff_on && bit_end) |=> (state_q != ST_STUFF));

endmodule

// File: rtl/usbfs_tx_drive.sv
module usbfs_tx_drive
    import usbfs_tx_pkg::*;
(
    input  logic       line_clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic [1:0] speed_sel,
    input  logic       busy,
    input  logic [1:0] sym,
    output logic       line_p,
    output logic       line_n,
    output logic       line_drive
);

    logic permit_q;

    always_ff @(posedge line_clk or negedge rst_n) begin
        if (!rst_n) begin
            permit_q <= 1'b0;
        end else begin
            permit_q <= (mode_sel != MODE_RELEASE) && (speed_sel != SPEED_HS);
        end
    end

    assign line_p     = sym[1];
    assign line_n     = sym[0];
    assign line_drive = permit_q & busy;

    // R8 and R10
    released_chk: assert property (@(posedge line_clk) disable iff (!rst_n)
        ((mode_sel == MODE_RELEASE) || (speed_sel == SPEED_HS)) |=> !line_drive);

    // R1
    idle_j_chk: assert property (@(posedge line_clk) disable iff (!rst_n)
        (!busy) |-> (line_p && !line_n && !line_drive));

endmodule

// File: rtl/usbfs_tx.sv
module usbfs_tx
    import usbfs_tx_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int CYC_PER_BIT = 4,
    parameter int STUFF_RUN   = 6,
    parameter int SE0_BITS    = 2
) (
    input  logic              byte_clk,
    input  logic              line_clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic [1:0]        mode_sel,
    input  logic [1:0]        speed_sel,
    output logic              line_p,
    output logic              line_n,
    output logic              line_drive
);

    logic              take_flag;
    logic              held_fresh;
    logic [BYTE_W-1:0] held_byte;
    logic              bit_end;
    logic              busy;
    logic [1:0]        sym;
    logic              stuff_on;

    assign stuff_on = (mode_sel != MODE_RAW);

    usbfs_tx_hold #(.BYTE_W(BYTE_W)) u_hold (
        .byte_clk   (byte_clk),
        .rst_n      (rst_n),
        .byte_in    (byte_in),
        .byte_valid (byte_valid),
        .byte_ready (byte_ready),
        .take_flag  (take_flag),
        .held_fresh (held_fresh),
        .held_byte  (held_byte)
    );

    usbfs_tx_bittimer #(.CYC_PER_BIT(CYC_PER_BIT)) u_timer (
        .line_clk (line_clk),
        .rst_n    (rst_n),
        .active   (busy),
        .bit_end  (bit_end)
    );

    usbfs_tx_engine #(
        .BYTE_W    (BYTE_W),
        .STUFF_RUN (STUFF_RUN),
        .SE0_BITS  (SE0_BITS)
    ) u_engine (
        .line_clk   (line_clk),
        .rst_n      (rst_n),
        .bit_end    (bit_end),
        .stuff_on   (stuff_on),
        .held_fresh (held_fresh),
        .held_byte  (held_byte),
        .take_flag  (take_flag),
        .busy       (busy),
        .sym        (sym)
    );

    usbfs_tx_drive u_drive (
        .line_clk   (line_clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .speed_sel  (speed_sel),
        .busy       (busy),
        .sym        (sym),
        .line_p     (line_p),
        .line_n     (line_n),
        .line_drive (line_drive)
    );

endmodule

// File: tb/test_usbfs_tx.sv
module test_usbfs_tx;

    logic       byte_clk = 1'b0;
    logic       line_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       byte_valid = 1'b0;
    logic       byte_ready;
    logic [1:0] mode_sel = 2'b00;
    logic [1:0] speed_sel = 2'b01;
    logic       line_p, line_n, line_drive;

    usbfs_tx i_usbfs_tx (
        .byte_clk   (byte_clk),
        .line_clk   (line_clk),
        .rst_n      (rst_n),
        .byte_in    (byte_in),
        .byte_valid (byte_valid),
        .byte_ready (byte_ready),
        .mode_sel   (mode_sel),
        .speed_sel  (speed_sel),
        .line_p     (line_p),
        .line_n     (line_n),
        .line_drive (line_drive)
    );

    typedef struct packed {
        logic [2:0] pins;   // {drive, p, n}
        logic [7:0] req;
    } exp_t;

    localparam logic [2:0] IDLE_PINS = 3'b010;

    int   vectors = 0;
    int   fails = 0;
    exp_t exp_q[$];
    logic [7:0] pkt_q[$];
    bit   launch = 0;
    bit   running = 0;

    // 250 MHz line clock; byte clock is a quarter of it with shared rising edges
    initial begin
        forever begin
            for (int k = 0; k < 4; k++) begin
                #2 line_clk = 1'b1;
                if (k == 0) byte_clk = 1'b1;
                if (k == 2) byte_clk = 1'b0;
                #2 line_clk = 1'b0;
            end
        end
    end

    task automatic check(input int req, input logic [2:0] act, input logic [2:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d at %0t: got %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic check_int(input int req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL R%0d at %0t: got %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // R7: each symbol is four line cycles; the last cycle of each carries the R7 tag
    task automatic put_sym(input logic drv, input logic [1:0] pn, input int req);
        exp_t e;
        for (int k = 0; k < 4; k++) begin
            e.pins = {drv, pn};
            e.req  = (k == 3) ? 8'd7 : 8'(req);
            exp_q.push_back(e);
        end
    endtask

    // Behavioural reference: sync (R3), payload LSB first NRZI (R4), stuffing (R5), end (R6)
    task automatic build(input bit stuff, input bit drv, input int ovr);
        bit bits[$];
        int rq[$];
        bit lvl = 1;
        int ones = 0;
        for (int b = 0; b < 8; b++) begin
            bits.push_back(((8'h80 >> b) & 1) != 0);
            rq.push_back(ovr != 0 ? ovr : 3);
        end
        foreach (pkt_q[i]) begin
            for (int b = 0; b < 8; b++) begin
                bits.push_back(pkt_q[i][b]);
                rq.push_back(ovr != 0 ? ovr : 4);
            end
        end
        for (int i = 0; i < bits.size(); i++) begin
            if (stuff && ones == 6) begin
                lvl = !lvl; ones = 0;
                put_sym(drv, lvl ? 2'b10 : 2'b01, ovr != 0 ? ovr : 5);
            end
            if (bits[i]) ones++;
            else begin lvl = !lvl; ones = 0; end
            put_sym(drv, lvl ? 2'b10 : 2'b01, rq[i]);
        end
        if (stuff && ones == 6) begin
            lvl = !lvl;
            put_sym(drv, lvl ? 2'b10 : 2'b01, ovr != 0 ? ovr : 5);
        end
        put_sym(drv, 2'b00, ovr != 0 ? ovr : 6);
        put_sym(drv, 2'b00, ovr != 0 ? ovr : 6);
        put_sym(drv, 2'b10, ovr != 0 ? ovr : 6);
    endtask

    // Pin comparison on every line-clock cycle, away from the rising edge
    always @(negedge line_clk) begin
        exp_t e;
        if (launch) begin
            launch = 0;
            running = 1;
            check(1, {line_drive, line_p, line_n}, IDLE_PINS);
        end else if (running && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check(int'(e.req), {line_drive, line_p, line_n}, e.pins);
            if (exp_q.size() == 0) running = 0;
        end else if (rst_n) begin
            check(1, {line_drive, line_p, line_n}, IDLE_PINS);   // R1 between packets
        end
    end

    task automatic send(input logic [1:0] mode, input logic [1:0] speed, input int ovr);
        int acc_n = 0;
        int idx = 0;
        bit first = 1;
        bit acc;
        @(posedge byte_clk); #1;
        mode_sel = mode;
        speed_sel = speed;
        build(mode != 2'b10, (mode != 2'b01) && (speed != 2'b00), ovr);
        @(posedge byte_clk); #1;
        byte_in = pkt_q[0];
        byte_valid = 1'b1;
        while (idx < pkt_q.size()) begin
            #12;
            acc = byte_ready;
            @(posedge byte_clk);
            if (acc) begin
                acc_n++;
                idx++;
                if (first) begin launch = 1; first = 0; end
            end
            #1;
            if (idx < pkt_q.size()) byte_in = pkt_q[idx];
            else byte_valid = 1'b0;
        end
        while (launch || running) @(negedge line_clk);
        repeat (4) @(posedge byte_clk);
        #1;
        check_int(2, acc_n, pkt_q.size());        // R2 one acceptance per byte
        check_int(2, int'(byte_ready), 0);        // R2 ready low with valid low
    endtask

    initial begin
        repeat (200000) @(posedge line_clk);
        fails++;
        $display("FAIL watchdog expired: got running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #7;
        // R1 reset state
        check(1, {line_drive, line_p, line_n}, IDLE_PINS);
        check_int(1, int'(byte_ready), 0);
        repeat (3) @(posedge byte_clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge byte_clk);

        // R3 R4 basic payload
        pkt_q = '{8'hA5, 8'h3C};
        send(2'b00, 2'b01, 0);
        // R5 run spanning the sync tail
        pkt_q = '{8'hFF, 8'h00};
        send(2'b00, 2'b01, 0);
        // R5 run completed by the last bit
        pkt_q = '{8'h01, 8'hFC};
        send(2'b00, 2'b01, 0);
        // R9 stuffing off
        pkt_q = '{8'hFF, 8'hFF};
        send(2'b10, 2'b01, 9);
        // R8 lines released
        pkt_q = '{8'h5A};
        send(2'b01, 2'b01, 8);
        // R10 high-speed select code
        pkt_q = '{8'hC3};
        send(2'b00, 2'b00, 10);
        // R11 reserved mode code acts as normal
        pkt_q = '{8'hFF, 8'h12, 8'h7F};
        send(2'b11, 2'b10, 11);
        // R6 shortest packet
        pkt_q = '{8'h00};
        send(2'b00, 2'b01, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule